// File: doc/BRIEF.md
# Activation Essential-Bit Offset Generator

This block turns one fixed-point activation word into a short serial stream of the positions of its nonzero bits. Each output term carries a power-of-two position, a sign and an end flag. Downstream shift-and-add lanes can then spend one cycle per essential bit instead of one cycle per bit of precision. Terms come out most significant first. Before conversion, the word can be trimmed by a per-layer count of leading and trailing bits to discard.

A word is offered with a valid/ready handshake and is taken only while the block is idle. The block then emits one registered term per cycle for as long as the consumer accepts. A mode input, sampled with each word, selects one of two encodings. Plain mode emits one positive term per set bit. Signed mode emits the non-adjacent signed-digit form, which folds runs of ones into a positive term above the run and negative terms at its bottom and at any gaps.

Signed mode can need position DATA_W, one above the top data bit, so the position field is one bit wider than the data index. A value of zero still produces one term, flagged as null, so that the consumer sees the end of every value.

Top module: `essbit_offset_gen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `out_valid` is 0 and `in_ready` is 1.
- R2: In plain mode (`in_signed`=0), the block emits exactly one term per set bit of the masked word. Positions strictly decrease from term to term, and every term has `out_neg`=0.
- R3: `out_last`=1 on the final term of a word and 0 on every other term.
- R4: A masked word equal to zero produces exactly one term, with `out_null`=1, `out_last`=1 and `out_pos`=0. `out_null` is 0 on every other term.
- R5: In signed mode (`in_signed`=1), the terms are the non-adjacent signed-digit form of the masked word, with `out_neg`=1 marking a digit of −1. The sum of ±2^pos equals the masked word, and positions strictly decrease. For example, 0x001B gives +5, −2, −0.
- R6: In signed mode, the number of terms never exceeds the popcount of the masked word, nor DATA_W/2+1.
- R7: Masking keeps bit i only when `in_trim_lo` ≤ i < DATA_W − `in_trim_hi`. All other bits are treated as zero.
- R8: While `out_valid`=1 and `out_ready`=0, the outputs `out_valid`, `out_pos`, `out_neg` and `out_last` hold their values.
- R9: `in_ready` falls on the cycle after a word is taken and stays 0 until the cycle after that word's last term is taken. No term is valid on the cycle after acceptance.
- R10: After a non-last term is taken, the next term is valid on the following cycle. With `out_ready` held at 1, a word of k terms therefore streams in k consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Activation word offered |
| in_ready | output | 1 | Block idle, word will be taken |
| in_data | input | DATA_W | Activation word |
| in_signed | input | 1 | 1 selects signed run-folding encoding |
| in_trim_hi | input | $clog2(DATA_W+1) | Number of most significant bits to clear |
| in_trim_lo | input | $clog2(DATA_W+1) | Number of least significant bits to clear |
| out_valid | output | 1 | Term present |
| out_ready | input | 1 | Consumer takes the term |
| out_pos | output | $clog2(DATA_W+1) | Power-of-two position of the term |
| out_neg | output | 1 | Term is negative |
| out_last | output | 1 | Final term of the word |
| out_null | output | 1 | Term stands for a zero word |

## Verification
A word is accepted on one edge, and its first term appears after the next edge. After that, each taken non-last term is followed by the next term one edge later. `in_ready` returns one edge after the last term is taken. The bench drives inputs and picks a random `out_ready` on the falling edge. It records a term only when `out_valid` and its own `out_ready` are both high on that falling edge, so each recorded term is exactly the one the next rising edge consumes. On the following falling edge, the bench checks that a held term is unchanged, that a new term follows a taken non-last one, and that `in_ready` behaves as required before the next word is offered.

// File: rtl/essbit_pkg.sv
package essbit_pkg;
  typedef enum logic {
    ENC_PLAIN  = 1'b0,
    ENC_SIGNED = 1'b1
  } enc_mode_e;
endpackage

// File: rtl/essbit_trim_mask.sv
module essbit_trim_mask #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [CNT_W-1:0]  trim_hi,
  input  logic [CNT_W-1:0]  trim_lo,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] keep;

  for (genvar g = 0; g < DATA_W; g++) begin : g_keep
    assign keep[g] = (32'(g) >= 32'(trim_lo)) &&
                     (32'(g) + 32'(trim_hi) < 32'(DATA_W));
  end

  assign dout = din & keep;
endmodule

// File: rtl/essbit_recode.sv
module essbit_recode
  import essbit_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int REM_W = DATA_W + 1
) (
  input  logic [DATA_W-1:0] val,
  input  enc_mode_e         mode,
  output logic [REM_W-1:0]  pos_bits,
  output logic [REM_W-1:0]  neg_bits
);
  logic [REM_W-1:0] v_ext, half, three_half, diff;

  assign v_ext      = {1'b0, val};
  assign half       = v_ext >> 1;
  assign three_half = v_ext + half;
  assign diff       = three_half ^ half;

  always_comb begin
    if (mode == ENC_SIGNED) begin
      pos_bits = three_half & diff;
      neg_bits = half & diff;
    end else begin
      pos_bits = v_ext;
      neg_bits = '0;
    end
  end
endmodule

// File: rtl/essbit_lod.sv
module essbit_lod #(
  parameter int W = 17,
  localparam int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     vec,
  output logic [IDX_W-1:0] idx,
  output logic             found
);
  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) begin
        idx   = IDX_W'(i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/essbit_offset_gen.sv
module essbit_offset_gen
  import essbit_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int CNT_W = $clog2(DATA_W + 1),
  localparam int REM_W = DATA_W + 1,
  localparam int POS_W = $clog2(REM_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_signed,
  input  logic [CNT_W-1:0]  in_trim_hi,
  input  logic [CNT_W-1:0]  in_trim_lo,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [POS_W-1:0]  out_pos,
  output logic              out_neg,
  output logic              out_last,
  output logic              out_null
);
  enc_mode_e         in_mode, mode_q;
  logic [DATA_W-1:0] masked;
  logic [REM_W-1:0]  load_p, load_n;
  logic [REM_W-1:0]  rem_p, rem_n, rem_any, top_oh, rem_after;
  logic [POS_W-1:0]  top_idx;
  logic              top_found, busy, step;

  assign in_mode = enc_mode_e'(in_signed);

  essbit_trim_mask #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_mask (
    .din(in_data), .trim_hi(in_trim_hi), .trim_lo(in_trim_lo), .dout(masked)
  );

  essbit_recode #(.DATA_W(DATA_W)) i_recode (
    .val(masked), .mode(in_mode), .pos_bits(load_p), .neg_bits(load_n)
  );

  assign rem_any = rem_p | rem_n;

  essbit_lod #(.W(REM_W)) i_lod (
    .vec(rem_any), .idx(top_idx), .found(top_found)
  );

  assign top_oh    = top_found ? (REM_W'(1) << top_idx) : '0;
  assign rem_after = rem_any & ~top_oh;
  assign step      = busy && (!out_valid || out_ready);
  assign in_ready  = !busy && !out_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      mode_q    <= ENC_PLAIN;
      rem_p     <= '0;
      rem_n     <= '0;
      out_valid <= 1'b0;
      out_pos   <= '0;
      out_neg   <= 1'b0;
      out_last  <= 1'b0;
      out_null  <= 1'b0;
    end else begin
      if (in_valid && in_ready) begin
        busy   <= 1'b1;
        mode_q <= in_mode;
        rem_p  <= load_p;
        rem_n  <= load_n;
      end
      if (step) begin
        out_valid <= 1'b1;
        out_pos   <= top_found ? top_idx : '0;
        out_neg   <= |(rem_n & top_oh);
        out_last  <= (rem_after == '0);
        out_null  <= !top_found;
        rem_p     <= rem_p & ~top_oh;
        rem_n     <= rem_n & ~top_oh;
        if (rem_after == '0) busy <= 1'b0;
      end else if (out_valid && out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  AST_HOLD_TERM: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_pos) &&
                                $stable(out_neg) && $stable(out_last)) // R8
    else $error("term changed under backpressure");

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> !in_ready && !out_valid) // R9
    else $error("accept did not close input");

  AST_READY_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && out_last |=> in_ready) // R9
    else $error("input not reopened after last term");

  AST_NULL_SHAPE: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_null |-> out_last && out_pos == '0) // R4
    else $error("null term malformed");

  AST_DESCENDING: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && !out_last |=> out_valid && out_pos < $past(out_pos)) // R10
    else $error("next term missing or not descending");

  AST_PLAIN_POSITIVE: assert property (@(posedge clk) disable iff (rst)
    out_valid && mode_q == ENC_PLAIN |-> !out_neg) // R2
    else $error("negative term in plain mode");
endmodule

// File: tb/test_essbit_offset_gen.sv
module test_essbit_offset_gen;
  localparam int DW = 16;
  localparam int CW = $clog2(DW + 1);
  localparam int PW = $clog2(DW + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic          in_signed = 1'b0;
  logic [CW-1:0] in_trim_hi = '0;
  logic [CW-1:0] in_trim_lo = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [PW-1:0] out_pos;
  logic          out_neg, out_last, out_null;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;
  int  exp_pos [0:17];
  bit  exp_neg [0:17];
  int  exp_n;
  int  exp_val;
  int  exp_pop;

  always #10 clk = ~clk;

  essbit_offset_gen #(.DATA_W(DW)) i_essbit_offset_gen (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_signed(in_signed), .in_trim_hi(in_trim_hi),
    .in_trim_lo(in_trim_lo), .out_valid(out_valid), .out_ready(out_ready),
    .out_pos(out_pos), .out_neg(out_neg), .out_last(out_last), .out_null(out_null)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic compute_exp(input logic [DW-1:0] d, input bit sm, input int th, input int tl);
    int v;
    int dg [0:17];
    exp_val = 0;
    exp_pop = 0;
    for (int i = 0; i < DW; i++)
      if (d[i] && i >= tl && i < DW - th) begin
        exp_val += (1 << i);
        exp_pop++;
      end
    exp_n = 0;
    if (exp_val == 0) begin
      exp_n = 1; exp_pos[0] = 0; exp_neg[0] = 1'b0;
    end else if (!sm) begin
      for (int i = DW - 1; i >= 0; i--)
        if ((exp_val >> i) & 1) begin
          exp_pos[exp_n] = i; exp_neg[exp_n] = 1'b0; exp_n++;
        end
    end else begin
      for (int i = 0; i < 18; i++) dg[i] = 0;
      v = exp_val;
      for (int k = 0; k < 18 && v != 0; k++) begin
        if (v % 2 != 0) begin
          dg[k] = 2 - (v % 4);
          v = v - dg[k];
        end
        v = v / 2;
      end
      for (int i = 17; i >= 0; i--)
        if (dg[i] != 0) begin
          exp_pos[exp_n] = i; exp_neg[exp_n] = (dg[i] < 0); exp_n++;
        end
    end
  endtask

  task automatic run_word(input logic [DW-1:0] d, input bit sm, input int th,
                          input int tl, input int pct);
    int got = 0;
    int sum = 0;
    bit fin = 1'b0;
    bit held = 1'b0;
    bit took_more = 1'b0;
    logic [PW-1:0] h_pos;
    logic h_neg, h_last;
    bit rdy;
    compute_exp(d, sm, th, tl);
    @(negedge clk);
    chk(in_ready == 1'b1, "R9 idle ready", int'(in_ready), 1);
    in_data = d; in_signed = sm;
    in_trim_hi = CW'(th); in_trim_lo = CW'(tl);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b0 && in_ready == 1'b0, "R9 no term in accept cycle",
        int'(out_valid), 0);
    while (!fin && got < 18) begin
      if (got > 0 || held || took_more) @(negedge clk);
      chk(in_ready == 1'b0, "R9 busy ready", int'(in_ready), 0);
      if (held)
        chk(out_valid && out_pos == h_pos && out_neg == h_neg && out_last == h_last,
            "R8 hold", int'(out_pos), int'(h_pos));
      if (took_more)
        chk(out_valid == 1'b1, "R10 next term", int'(out_valid), 1);
      rdy = (($urandom % 100) < pct);
      out_ready = rdy;
      held = out_valid && !rdy;
      took_more = 1'b0;
      h_pos = out_pos; h_neg = out_neg; h_last = out_last;
      if (out_valid && rdy) begin
        if (got < exp_n) begin
          chk(out_pos == PW'(exp_pos[got]), sm ? "R5 pos" : "R2 pos",
              int'(out_pos), exp_pos[got]);
          chk(out_neg == exp_neg[got], sm ? "R5 sign" : "R2 sign",
              int'(out_neg), int'(exp_neg[got]));
          chk(out_last == (got == exp_n - 1), "R3 last flag",
              int'(out_last), int'(got == exp_n - 1));
          chk(out_null == (exp_val == 0), "R4 null flag",
              int'(out_null), int'(exp_val == 0));
        end
        if (!out_null) sum += out_neg ? -(1 << out_pos) : (1 << out_pos);
        got++;
        fin = out_last;
        took_more = !out_last;
      end
      if (!fin && !held && !took_more) begin
        @(negedge clk);
        held = 1'b0;
        took_more = 1'b0;
        got = got;
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
    chk(in_ready == 1'b1, "R9 ready after last", int'(in_ready), 1);
    chk(got == exp_n, "R2 term count", got, exp_n);
    chk(sum == exp_val, "R7 value sum", sum, exp_val);
    if (sm) begin
      chk(got <= exp_pop || exp_val == 0, "R6 popcount bound", got, exp_pop);
      chk(got <= DW / 2 + 1, "R6 length bound", got, DW / 2 + 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R10 actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R1 in reset", int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R1 after reset", int'(in_ready), 1);

    run_word(16'h0005, 1'b0, 0, 0, 100);   // R2 R3 plain 101
    run_word(16'h001B, 1'b1, 0, 0, 100);   // R5 +5 -2 -0
    run_word(16'h0000, 1'b0, 0, 0, 100);   // R4 null plain
    run_word(16'h0000, 1'b1, 0, 0, 60);    // R4 null signed
    run_word(16'hFFFF, 1'b0, 0, 0, 100);   // R10 full stream
    run_word(16'hFFFF, 1'b1, 0, 0, 40);    // R5 top position 16
    run_word(16'h8000, 1'b1, 0, 0, 100);   // R5 single top bit
    run_word(16'hFFFF, 1'b0, 4, 4, 50);    // R7 both trims
    run_word(16'h00F0, 1'b0, 0, 8, 100);   // R7 trimmed to zero, R4
    run_word(16'hFFFF, 1'b1, 16, 0, 100);  // R7 full prefix trim
    run_word(16'h5555, 1'b1, 0, 0, 30);    // R6 alternating worst case
    run_word(16'hAAAB, 1'b1, 0, 0, 30);    // R6

    for (int n = 0; n < 400; n++) begin
      d = DW'($urandom);
      if (n % 3 == 0) d = d & DW'($urandom) & DW'($urandom);
      run_word(d, 1'($urandom), (n % 5 == 0) ? int'($urandom % 17) : 0,
               (n % 7 == 0) ? int'($urandom % 17) : 0,
               (n % 4 == 0) ? 100 : 20 + int'($urandom % 70));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule